// File: doc/BRIEF.md
# Adaptive Serial Lane Width Controller

This controller governs how many serial lanes one direction of a point-to-point link keeps powered. After reset every lane is off. Once the PLL reports lock, the controller sends a capability request to the far end over the sideband. It starts operating only when the far end's capability answer arrives. From then on it selects zero, one or four lanes. The selection follows the outbound traffic level, a pending-transfer flag and an optional forced mode taken from the power-management register.

Widening powers the new lanes and raises a sideband power-up event for each of them. The new width is reported to the datapath only when two things have happened: a sleep mask interval has elapsed, and every newly powered lane has returned its ready event. Narrowing is reported at once, so the datapath stops using the lanes being dropped. Those lanes are switched off after a disable mask interval.

Each mask interval is a programmed count times 16 symbol times, with one clock cycle taken as one symbol time. Transmit and receive each use their own instance, so one direction can run while the other sits at zero lanes.

Top module: `lwc_lane_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the PLL lock input is seen high, `lane_pwr` is all zero, `link_ready` and `active_mode` are zero, and `sb_cap_req` stays low.
- R2: After lock is seen, `sb_cap_req` pulses high for exactly one cycle. No lane is powered until a capability answer (`sb_cap_valid`) arrives, even with a transfer pending.
- R3: In the capability answer, bit 0 is reported on `peer_fast`, and bit 1 permits four-lane operation. Bits 3:2 have no effect. Without bit 1 the controller stays at one lane under any load.
- R4: At zero lanes the controller waits for `xfer_pending`. It then powers exactly lane 0 (`lane_pwr`=0001) and raises `sb_pwrup_evt`=0001 for one cycle.
- R5: `active_mode` encoding is 0 = zero lanes, 1 = one lane (lane 0), 2 = four lanes (all). The controller moves from one lane to four when `load_level >= cfg_up_thr`. It moves from four lanes to one when `load_level < cfg_dn_thr`. It moves from one lane to zero when `load_level == 0` and no transfer is pending. Loads between the two thresholds keep the current mode.
- R6: A load-driven change (R5) happens only after its condition has held for `cfg_dwell`+1 consecutive cycles. A shorter burst causes no change.
- R7: With `pm_force_en` high, `pm_force_code` sets the mode regardless of load: 0 = zero lanes, 1 = one lane, 2 or 3 = four lanes. Four lanes fall back to one lane if the peer lacks four-lane capability.
- R8: `sb_pwrup_evt` flags only lanes that were unpowered before. A wider mode appears on `active_mode` only after every newly powered lane has asserted its `sb_lane_ready` bit.
- R9: When ready events are already present, a wider mode is reported exactly `cfg_sleep_cnt`*16+1 cycles after the cycle that shows the power-up event.
- R10: A narrower mode is reported immediately. The dropped lanes turn off `cfg_disable_cnt`*16+1 cycles after the cycle that shows the narrower mode.
- R11: `link_ready` is high exactly when `active_mode` is non-zero, and lane 0 is then powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_locked | input | 1 | PLL lock indication |
| xfer_pending | input | 1 | Outbound transfer waiting |
| load_level | input | LOAD_W | Outbound traffic load measure |
| cfg_up_thr | input | LOAD_W | Load at or above which four lanes are wanted |
| cfg_dn_thr | input | LOAD_W | Load below which four lanes are left |
| cfg_dwell | input | DWELL_W | Extra cycles a load condition must persist |
| cfg_sleep_cnt | input | MASK_W | Sleep mask, units of 16 symbols |
| cfg_disable_cnt | input | MASK_W | Disable mask, units of 16 symbols |
| pm_force_en | input | 1 | Forced-mode enable |
| pm_force_code | input | 2 | Forced mode code |
| sb_cap_valid | input | 1 | Capability answer strobe from peer |
| sb_cap_word | input | 4 | Capability answer bits |
| sb_lane_ready | input | NLANES | Per-lane ready events from peer |
| sb_cap_req | output | 1 | Capability request pulse |
| sb_pwrup_evt | output | NLANES | Per-lane power-up event pulses |
| lane_pwr | output | NLANES | Per-lane power/enable |
| active_mode | output | 2 | Mode reported to the datapath |
| link_ready | output | 1 | At least one lane usable for data |
| peer_fast | output | 1 | Peer supports rates above base |

## Verification
Some rules are checked on every cycle:
- no capability request while the PLL is unlocked;
- the request is a single-cycle pulse;
- power-up events match exactly the lanes that turned on;
- four-lane reporting implies all lanes powered and four-lane capability granted;
- `link_ready` agrees with the mode and lane 0.

Other behaviours need timed scenarios, and only the bench shows them:
- the exact sleep and disable mask delays;
- hysteresis between the thresholds;
- dwell filtering of short bursts;
- holding the narrow mode while a new lane withholds its ready event;
- the forced-mode table.

// File: rtl/lwc_pkg.sv
`timescale 1ns/1ps
package lwc_pkg;

    typedef enum logic [1:0] {
        L_ZERO = 2'd0,
        L_ONE  = 2'd1,
        L_FOUR = 2'd2
    } lmode_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } link_st_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DN   = 2'd2
    } phase_e;

    localparam int unsigned MASK_SHIFT = 4;  // 16 symbol times per count unit

endpackage

// File: rtl/lwc_mask_timer.sv
`timescale 1ns/1ps
module lwc_mask_timer
    import lwc_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] units,
    output logic             done
);
    localparam int unsigned TW = CNT_W + MASK_SHIFT;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = {units, {MASK_SHIFT{1'b0}}};
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lwc_mode_pick.sv
`timescale 1ns/1ps
module lwc_mode_pick
    import lwc_pkg::*;
#(
    parameter int unsigned LOAD_W  = 8,
    parameter int unsigned DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  lmode_e             cur,
    input  logic               cap4,
    input  logic               pend,
    input  logic [LOAD_W-1:0]  load,
    input  logic [LOAD_W-1:0]  up_thr,
    input  logic [LOAD_W-1:0]  dn_thr,
    input  logic [DWELL_W-1:0] dwell_lim,
    input  logic               force_en,
    input  logic [1:0]         force_code,
    output lmode_e             want
);
    logic [DWELL_W-1:0] dwell_d, dwell_q;
    logic               cond;
    lmode_e             nxt;
    lmode_e             forced;

    always_comb begin
        case (force_code)
            2'd0:    forced = L_ZERO;
            2'd1:    forced = L_ONE;
            default: forced = cap4 ? L_FOUR : L_ONE;
        endcase

        cond = 1'b0;
        nxt  = cur;
        case (cur)
            L_ONE: begin
                if (cap4 && (load >= up_thr)) begin
                    cond = 1'b1;
                    nxt  = L_FOUR;
                end else if ((load == '0) && !pend) begin
                    cond = 1'b1;
                    nxt  = L_ZERO;
                end
            end
            L_FOUR: begin
                if (load < dn_thr) begin
                    cond = 1'b1;
                    nxt  = L_ONE;
                end
            end
            default: begin
                if (pend) begin
                    nxt = L_ONE;
                end
            end
        endcase

        if (force_en) begin
            want = forced;
        end else if (cur == L_ZERO) begin
            want = nxt;
        end else if (cond && (dwell_q >= dwell_lim)) begin
            want = nxt;
        end else begin
            want = cur;
        end

        dwell_d = '0;
        if (en && cond && !force_en) begin
            dwell_d = (dwell_q == '1) ? dwell_q : dwell_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else begin
            dwell_q <= dwell_d;
        end
    end

endmodule

// File: rtl/lwc_lane_ctrl.sv
`timescale 1ns/1ps
module lwc_lane_ctrl
    import lwc_pkg::*;
#(
    parameter int unsigned NLANES  = 4,
    parameter int unsigned LOAD_W  = 8,
    parameter int unsigned DWELL_W = 8,
    parameter int unsigned MASK_W  = 8,
    parameter int unsigned CAP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pll_locked,
    input  logic               xfer_pending,
    input  logic [LOAD_W-1:0]  load_level,
    input  logic [LOAD_W-1:0]  cfg_up_thr,
    input  logic [LOAD_W-1:0]  cfg_dn_thr,
    input  logic [DWELL_W-1:0] cfg_dwell,
    input  logic [MASK_W-1:0]  cfg_sleep_cnt,
    input  logic [MASK_W-1:0]  cfg_disable_cnt,
    input  logic               pm_force_en,
    input  logic [1:0]         pm_force_code,
    input  logic               sb_cap_valid,
    input  logic [CAP_W-1:0]   sb_cap_word,
    input  logic [NLANES-1:0]  sb_lane_ready,
    output logic               sb_cap_req,
    output logic [NLANES-1:0]  sb_pwrup_evt,
    output logic [NLANES-1:0]  lane_pwr,
    output logic [1:0]         active_mode,
    output logic               link_ready,
    output logic               peer_fast
);
    localparam logic [NLANES-1:0] MASK_ALL = {NLANES{1'b1}};
    localparam logic [NLANES-1:0] MASK_ONE = {{(NLANES-1){1'b0}}, 1'b1};

    typedef struct packed {
        link_st_e          st;
        phase_e            ph;
        lmode_e            rep;
        lmode_e            tgt;
        logic              peer4;
        logic              fast;
        logic              capreq;
        logic [NLANES-1:0] pwr;
        logic [NLANES-1:0] need;
        logic [NLANES-1:0] rdy;
        logic [NLANES-1:0] evt;
    } ctrl_t;

    ctrl_t q, n;

    logic              tmr_load;
    logic [MASK_W-1:0] tmr_units;
    logic              tmr_done;
    logic              pick_en;
    lmode_e            want;
    logic [NLANES-1:0] rdy_now;
    logic [NLANES-1:0] want_mask;
    logic              cap_unused;

    assign cap_unused = ^sb_cap_word[CAP_W-1:2];

    function automatic logic [NLANES-1:0] lanes_of(input lmode_e m);
        case (m)
            L_ONE:   return MASK_ONE;
            L_FOUR:  return MASK_ALL;
            default: return '0;
        endcase
    endfunction

    lwc_mode_pick #(
        .LOAD_W  (LOAD_W),
        .DWELL_W (DWELL_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (pick_en),
        .cur        (q.rep),
        .cap4       (q.peer4),
        .pend       (xfer_pending),
        .load       (load_level),
        .up_thr     (cfg_up_thr),
        .dn_thr     (cfg_dn_thr),
        .dwell_lim  (cfg_dwell),
        .force_en   (pm_force_en),
        .force_code (pm_force_code),
        .want       (want)
    );

    lwc_mask_timer #(
        .CNT_W (MASK_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .units (tmr_units),
        .done  (tmr_done)
    );

    always_comb begin
        n         = q;
        n.evt     = '0;
        n.capreq  = 1'b0;
        tmr_load  = 1'b0;
        tmr_units = cfg_sleep_cnt;
        pick_en   = 1'b0;
        rdy_now   = q.rdy | (sb_lane_ready & q.need);
        want_mask = lanes_of(want);

        case (q.st)
            ST_OFF: begin
                if (pll_locked) begin
                    n.capreq = 1'b1;
                    n.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sb_cap_valid) begin
                    n.peer4 = sb_cap_word[1];
                    n.fast  = sb_cap_word[0];
                    n.st    = ST_RUN;
                end
            end
            default: begin
                case (q.ph)
                    PH_UP: begin
                        n.rdy = rdy_now;
                        if (tmr_done && ((rdy_now & q.need) == q.need)) begin
                            n.rep = q.tgt;
                            n.ph  = PH_IDLE;
                        end
                    end
                    PH_DN: begin
                        if (tmr_done) begin
                            n.pwr = lanes_of(q.tgt);
                            n.ph  = PH_IDLE;
                        end
                    end
                    default: begin
                        pick_en = 1'b1;
                        if (want > q.rep) begin
                            n.pwr     = want_mask;
                            n.evt     = want_mask & ~q.pwr;
                            n.need    = want_mask & ~q.pwr;
                            n.rdy     = '0;
                            n.tgt     = want;
                            n.ph      = PH_UP;
                            tmr_load  = 1'b1;
                            tmr_units = cfg_sleep_cnt;
                        end else if (want < q.rep) begin
                            n.rep     = want;
                            n.tgt     = want;
                            n.ph      = PH_DN;
                            tmr_load  = 1'b1;
                            tmr_units = cfg_disable_cnt;
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_OFF;
            q.ph     <= PH_IDLE;
            q.rep    <= L_ZERO;
            q.tgt    <= L_ZERO;
            q.peer4  <= 1'b0;
            q.fast   <= 1'b0;
            q.capreq <= 1'b0;
            q.pwr    <= '0;
            q.need   <= '0;
            q.rdy    <= '0;
            q.evt    <= '0;
        end else begin
            q <= n;
        end
    end

    assign sb_cap_req   = q.capreq;
    assign sb_pwrup_evt = q.evt;
    assign lane_pwr     = q.pwr;
    assign active_mode  = q.rep;
    assign link_ready   = (q.rep != L_ZERO);
    assign peer_fast    = q.fast;

endmodule

// File: rtl/lwc_lane_ctrl_chk.sv
`timescale 1ns/1ps
module lwc_lane_ctrl_chk #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned CAP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_locked,
    input logic              sb_cap_valid,
    input logic [CAP_W-1:0]  sb_cap_word,
    input logic              sb_cap_req,
    input logic [NLANES-1:0] sb_pwrup_evt,
    input logic [NLANES-1:0] lane_pwr,
    input logic [1:0]        active_mode,
    input logic              link_ready
);
    logic req_seen_q, got_q, cap4_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_q <= 1'b0;
            got_q      <= 1'b0;
            cap4_q     <= 1'b0;
        end else begin
            if (sb_cap_req) req_seen_q <= 1'b1;
            if (req_seen_q && sb_cap_valid && !got_q) begin
                got_q  <= 1'b1;
                cap4_q <= sb_cap_word[1];
            end
        end
    end

    assert_no_req_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> !sb_cap_req);

    assert_req_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sb_cap_req |=> !sb_cap_req);

    assert_no_four_without_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'd2) |-> cap4_q);

    assert_four_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'd2) |-> (lane_pwr == {NLANES{1'b1}}));

    assert_evt_new_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(lane_pwr) |-> ((lane_pwr & ~$past(lane_pwr)) == sb_pwrup_evt));

    assert_evt_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_pwrup_evt != '0) |-> ((sb_pwrup_evt & lane_pwr) == sb_pwrup_evt));

    assert_ready_lane0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> (lane_pwr[0] && (active_mode != 2'd0)));

    assert_mode_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_mode != 2'd3);

endmodule

bind lwc_lane_ctrl lwc_lane_ctrl_chk #(
    .NLANES (NLANES),
    .CAP_W  (CAP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_locked   (pll_locked),
    .sb_cap_valid (sb_cap_valid),
    .sb_cap_word  (sb_cap_word),
    .sb_cap_req   (sb_cap_req),
    .sb_pwrup_evt (sb_pwrup_evt),
    .lane_pwr     (lane_pwr),
    .active_mode  (active_mode),
    .link_ready   (link_ready)
);

// File: tb/sim_lwc_lane_ctrl.sv
`timescale 1ns/1ps
module sim_lwc_lane_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_locked = 1'b0;
    logic       xfer_pending = 1'b0;
    logic [7:0] load_level = '0;
    logic [7:0] cfg_up_thr = 8'd100;
    logic [7:0] cfg_dn_thr = 8'd50;
    logic [7:0] cfg_dwell = 8'd3;
    logic [7:0] cfg_sleep_cnt = 8'd1;
    logic [7:0] cfg_disable_cnt = 8'd1;
    logic       pm_force_en = 1'b0;
    logic [1:0] pm_force_code = 2'd0;
    logic       sb_cap_valid = 1'b0;
    logic [3:0] sb_cap_word = '0;
    logic [3:0] sb_lane_ready = 4'b1111;
    logic       sb_cap_req;
    logic [3:0] sb_pwrup_evt;
    logic [3:0] lane_pwr;
    logic [1:0] active_mode;
    logic       link_ready;
    logic       peer_fast;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lwc_lane_ctrl u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .pll_locked      (pll_locked),
        .xfer_pending    (xfer_pending),
        .load_level      (load_level),
        .cfg_up_thr      (cfg_up_thr),
        .cfg_dn_thr      (cfg_dn_thr),
        .cfg_dwell       (cfg_dwell),
        .cfg_sleep_cnt   (cfg_sleep_cnt),
        .cfg_disable_cnt (cfg_disable_cnt),
        .pm_force_en     (pm_force_en),
        .pm_force_code   (pm_force_code),
        .sb_cap_valid    (sb_cap_valid),
        .sb_cap_word     (sb_cap_word),
        .sb_lane_ready   (sb_lane_ready),
        .sb_cap_req      (sb_cap_req),
        .sb_pwrup_evt    (sb_pwrup_evt),
        .lane_pwr        (lane_pwr),
        .active_mode     (active_mode),
        .link_ready      (link_ready),
        .peer_fast       (peer_fast)
    );

    // {force_en, force_code, pend, load, exp_mode, exp_pwr}
    localparam logic [17:0] TBL [0:10] = '{
        {1'b0, 2'd0, 1'b0, 8'd0,   2'd0, 4'b0000},
        {1'b0, 2'd0, 1'b1, 8'd5,   2'd1, 4'b0001},
        {1'b0, 2'd0, 1'b1, 8'd200, 2'd2, 4'b1111},
        {1'b0, 2'd0, 1'b1, 8'd60,  2'd2, 4'b1111},
        {1'b0, 2'd0, 1'b1, 8'd30,  2'd1, 4'b0001},
        {1'b0, 2'd0, 1'b1, 8'd60,  2'd1, 4'b0001},
        {1'b0, 2'd0, 1'b0, 8'd0,   2'd0, 4'b0000},
        {1'b1, 2'd2, 1'b0, 8'd0,   2'd2, 4'b1111},
        {1'b1, 2'd0, 1'b1, 8'd200, 2'd0, 4'b0000},
        {1'b1, 2'd1, 1'b0, 8'd0,   2'd1, 4'b0001},
        {1'b0, 2'd0, 1'b0, 8'd0,   2'd0, 4'b0000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pll_locked = 1'b0;
        xfer_pending = 1'b0;
        load_level = '0;
        pm_force_en = 1'b0;
        sb_cap_valid = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic bring_up(input logic [3:0] cap);
        int seen = 0;
        pll_locked = 1'b1;
        for (int i = 0; i < 10 && seen == 0; i++) begin
            @(negedge clk);
            if (sb_cap_req) seen = 1;
        end
        chk("R2", "cap request seen", seen, 1);
        @(negedge clk);
        chk("R2", "cap request one cycle", int'(sb_cap_req), 0);
        sb_cap_word = cap;
        sb_cap_valid = 1'b1;
        @(negedge clk);
        sb_cap_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        int req_cnt;
        logic [3:0] ev;

        // Table walk runs after bring-up; first directed reset checks.
        do_reset();
        @(negedge clk);
        chk("R1", "lane_pwr after reset", int'(lane_pwr), 0);
        chk("R1", "link_ready after reset", int'(link_ready), 0);
        chk("R1", "active_mode after reset", int'(active_mode), 0);
        req_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sb_cap_req) req_cnt++;
        end
        chk("R1", "cap request while unlocked", req_cnt, 0);

        // Session 1: peer without four-lane capability, upper bits set.
        xfer_pending = 1'b1;
        pll_locked = 1'b1;
        cnt = 0;
        for (int i = 0; i < 10 && !sb_cap_req; i++) @(negedge clk);
        chk("R2", "cap request after lock", int'(sb_cap_req), 1);
        @(negedge clk);
        chk("R2", "cap request pulse width", int'(sb_cap_req), 0);
        cyc(20);
        chk("R2", "no lane before cap answer", int'(lane_pwr), 0);
        sb_cap_word = 4'b1101;
        sb_cap_valid = 1'b1;
        ev = '0;
        for (int i = 0; i < 10 && ev == 0; i++) begin
            @(negedge clk);
            sb_cap_valid = 1'b0;
            ev = sb_pwrup_evt;
        end
        chk("R3", "peer_fast from bit 0", int'(peer_fast), 1);
        chk("R4", "power-up event lane 0 only", int'(ev), 1);
        chk("R4", "lane_pwr one lane", int'(lane_pwr), 1);
        cnt = 0;
        while (!link_ready && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9", "sleep mask delay", cnt, 17);
        load_level = 8'd200;
        cyc(100);
        chk("R3", "no four lanes without capability", int'(active_mode), 1);
        chk("R3", "lanes stay single", int'(lane_pwr), 1);

        // Session 2: four-lane capable peer, lanes 1-3 late with ready.
        do_reset();
        sb_lane_ready = 4'b0001;
        xfer_pending = 1'b1;
        load_level = 8'd200;
        bring_up(4'b0010);
        chk("R3", "peer_fast clear", int'(peer_fast), 0);
        cnt = 0;
        while (lane_pwr != 4'b1111 && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk("R8", "events only for new lanes", int'(sb_pwrup_evt), 4'b1110);
        cyc(60);
        chk("R8", "narrow mode held without ready", int'(active_mode), 1);
        chk("R11", "link ready during widening", int'(link_ready), 1);
        sb_lane_ready = 4'b1111;
        cyc(3);
        chk("R8", "four lanes after ready", int'(active_mode), 2);

        // Dwell filtering.
        load_level = 8'd30;
        cyc(60);
        chk("R5", "down to one lane", int'(active_mode), 1);
        chk("R10", "upper lanes off", int'(lane_pwr), 1);
        load_level = 8'd200;
        cyc(3);
        load_level = 8'd30;
        cyc(30);
        chk("R6", "short burst ignored", int'(lane_pwr), 1);
        load_level = 8'd200;
        cyc(4);
        chk("R6", "burst of dwell+1 widens", int'(lane_pwr), 4'b1111);
        cyc(40);
        chk("R5", "four lanes under load", int'(active_mode), 2);

        // Disable mask: go down to one lane, then to zero.
        load_level = 8'd30;
        cyc(60);
        load_level = '0;
        xfer_pending = 1'b0;
        cnt = 0;
        while (link_ready && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk("R10", "mode drops at once", int'(active_mode), 0);
        chk("R10", "lane still on at drop", int'(lane_pwr), 1);
        cnt = 0;
        while (lane_pwr != 0 && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk("R10", "disable mask delay", cnt, 17);

        // Vector table: load and forced modes (R5, R7, R11).
        for (int v = 0; v < 11; v++) begin
            pm_force_en   = TBL[v][17];
            pm_force_code = TBL[v][16:15];
            xfer_pending  = TBL[v][14];
            load_level    = TBL[v][13:6];
            cyc(80);
            chk(TBL[v][17] ? "R7" : "R5", $sformatf("vec %0d mode", v),
                int'(active_mode), int'(TBL[v][5:4]));
            chk(TBL[v][17] ? "R7" : "R5", $sformatf("vec %0d lanes", v),
                int'(lane_pwr), int'(TBL[v][3:0]));
            chk("R11", $sformatf("vec %0d link_ready", v),
                int'(link_ready), int'(TBL[v][5:4] != 2'd0));
        end

        // Forced four lanes with a peer lacking capability clamps to one.
        do_reset();
        bring_up(4'b0001);
        pm_force_en = 1'b1;
        pm_force_code = 2'd3;
        cyc(60);
        chk("R7", "forced four clamped", int'(active_mode), 1);
        chk("R7", "forced four clamped lanes", int'(lane_pwr), 1);

        finish_run();
    end

endmodule